// File: doc/BRIEF.md
# Flash Erase and Program Engine

This engine holds a small on-chip byte array that stands in for the contents of a serial flash device. A command sequencer sits in front of it and drives one request per cycle. A request can load the byte pointer, read the byte at the pointer, program the byte at the pointer, or erase a region around a given address. Reads and programs advance the pointer, so a stream of data bytes from the sequencer lands at consecutive addresses.

Programming follows flash rules by default: a bit can only go from 1 to 0. A rewrite input lets a program store the data byte as given, which is how EEPROM-like parts behave. Erase fills a region with 0xFF. It runs as a sweep of one byte per clock and holds `busy` high while it runs.

Two inputs gate the work. An erase only happens while the write-enable input is high. A two-bit capability mask says which of the small erase sizes the modelled part supports. An erase size the part does not support raises an error pulse, and the erase still goes ahead. A program issued without write enable is still applied, but it raises a warning pulse.

Top module: `flash_eng`

## Requirements
- R1: The erase kind is given on `req_kind`: 0 is the small erase (SMALL_ERASE_BYTES, 4 KiB in full-size builds), 1 is the mid erase (MID_ERASE_BYTES, 32 KiB in full-size builds), 2 is the sector erase (SECTOR_BYTES) and 3 is the whole array. The start address is aligned down to a multiple of the length. A length larger than the array is treated as the whole array.
- R2: Every byte in the erased region reads 0xFF once `busy` has fallen. The bytes just below and just above the region keep their values.
- R3: An erase request made while `wr_en` is low is dropped. `busy` stays low and the array is unchanged.
- R4: A kind-0 erase with `cap_mask[0]` low, or a kind-1 erase with `cap_mask[1]` low, gives a one-cycle `cap_err` pulse in the cycle after the request. The erase still runs. Kinds 2 and 3 never raise `cap_err`.
- R5: A program stores (old AND data) when `rewrite_ones` is low, and stores data as given when `rewrite_ones` is high.
- R6: Op codes on `req_op` are: 0 loads the pointer from `req_addr`, 1 reads, 2 programs, 3 erases at `req_addr`. Reads and programs each advance the pointer by one. The pointer wraps from the top address to 0.
- R7: A program made while `wr_en` is low gives a one-cycle `prog_warn` pulse in the cycle after the request, and the byte is still written.
- R8: An accepted erase raises `busy` in the cycle after the request. `busy` stays high for exactly as many cycles as the region has bytes. While `busy` is high, program and erase requests are ignored: they write nothing and do not move the pointer.
- R9: After reset every byte reads 0xFF, the pointer is 0, and `busy`, `rd_valid`, `prog_warn` and `cap_err` are low.
- R10: A read puts the addressed byte on `rd_data` and pulses `rd_valid` in the cycle after the request. Reads and pointer loads are accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (R6) |
| req_kind | input | 2 | Erase kind (R1) |
| req_addr | input | AW | Pointer load value or erase address |
| req_data | input | 8 | Program data byte |
| wr_en | input | 1 | Write enable |
| cap_mask | input | 2 | Supported small (bit 0) and mid (bit 1) erase sizes |
| rewrite_ones | input | 1 | Program stores data as given |
| busy | output | 1 | Erase sweep running |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid pulse |
| prog_warn | output | 1 | Program without write enable pulse |
| cap_err | output | 1 | Unsupported erase size pulse |

## Verification
The bench builds the engine with a 512-byte array, a 32-byte small erase, a 64-byte mid erase and a 128-byte sector. With these sizes each erase kind finishes in a few hundred cycles, and the regions sit apart from one another inside the array. That makes it possible to count every `busy` cycle against the region length, and to check the bytes just outside each aligned region. The whole-array erase and the pointer wrap at the top address can also be covered within a short run.

// File: rtl/flash_eng_pkg.sv
`timescale 1ns/1ps
package flash_eng_pkg;
    localparam logic [1:0] OP_SETADDR = 2'd0;
    localparam logic [1:0] OP_READ    = 2'd1;
    localparam logic [1:0] OP_PROG    = 2'd2;
    localparam logic [1:0] OP_ERASE   = 2'd3;

    localparam logic [1:0] KIND_SMALL  = 2'd0;
    localparam logic [1:0] KIND_MID    = 2'd1;
    localparam logic [1:0] KIND_SECTOR = 2'd2;
    localparam logic [1:0] KIND_CHIP   = 2'd3;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic int clamp_len(input int want, input int total);
        return (want > total) ? total : want;
    endfunction
endpackage

// File: rtl/flash_erase_geom.sv
`timescale 1ns/1ps
module flash_erase_geom
    import flash_eng_pkg::*;
#(
    parameter int ARRAY_BYTES       = 1024,
    parameter int SECTOR_BYTES      = 256,
    parameter int SMALL_ERASE_BYTES = 64,
    parameter int MID_ERASE_BYTES   = 128,
    parameter int AW                = $clog2(ARRAY_BYTES)
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    cap_mask,
    output logic [AW-1:0] base,
    output logic [AW:0]   len,
    output logic          cap_fault
);
    localparam logic [AW:0] LEN_SMALL  = (AW+1)'(clamp_len(SMALL_ERASE_BYTES, ARRAY_BYTES));
    localparam logic [AW:0] LEN_MID    = (AW+1)'(clamp_len(MID_ERASE_BYTES, ARRAY_BYTES));
    localparam logic [AW:0] LEN_SECTOR = (AW+1)'(clamp_len(SECTOR_BYTES, ARRAY_BYTES));
    localparam logic [AW:0] LEN_CHIP   = (AW+1)'(ARRAY_BYTES);

    logic [AW:0] span_mask;

    always_comb begin
        case (kind)
            KIND_SMALL:  len = LEN_SMALL;
            KIND_MID:    len = LEN_MID;
            KIND_SECTOR: len = LEN_SECTOR;
            default:     len = LEN_CHIP;
        endcase
        span_mask = len - (AW+1)'(1);
        base      = addr & ~span_mask[AW-1:0];
        cap_fault = ((kind == KIND_SMALL) && !cap_mask[0])
                 || ((kind == KIND_MID)   && !cap_mask[1]);
    end
endmodule

// File: rtl/flash_byte_array.sv
`timescale 1ns/1ps
module flash_byte_array
    import flash_eng_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= ERASED_BYTE;
            end
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/flash_eng.sv
`timescale 1ns/1ps
module flash_eng
    import flash_eng_pkg::*;
#(
    parameter int ARRAY_BYTES       = 1024,
    parameter int SECTOR_BYTES      = 256,
    parameter int SMALL_ERASE_BYTES = 64,
    parameter int MID_ERASE_BYTES   = 128,
    localparam int AW               = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          wr_en,
    input  logic [1:0]    cap_mask,
    input  logic          rewrite_ones,
    output logic          busy,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic          prog_warn,
    output logic          cap_err
);
    typedef struct packed {
        logic          busy;
        logic [AW-1:0] ptr;
        logic [AW-1:0] sweep;
        logic [AW:0]   left;
        logic [7:0]    rd;
        logic          rd_v;
        logic          warn;
        logic          cap;
    } eng_state_t;

    eng_state_t state_d, state_q;

    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [7:0]    arr_wdata;
    logic [7:0]    arr_rdata;
    logic [AW-1:0] geo_base;
    logic [AW:0]   geo_len;
    logic          geo_fault;

    flash_erase_geom #(
        .ARRAY_BYTES       (ARRAY_BYTES),
        .SECTOR_BYTES      (SECTOR_BYTES),
        .SMALL_ERASE_BYTES (SMALL_ERASE_BYTES),
        .MID_ERASE_BYTES   (MID_ERASE_BYTES),
        .AW                (AW)
    ) geom_i (
        .kind      (req_kind),
        .addr      (req_addr),
        .cap_mask  (cap_mask),
        .base      (geo_base),
        .len       (geo_len),
        .cap_fault (geo_fault)
    );

    flash_byte_array #(
        .DEPTH (ARRAY_BYTES),
        .AW    (AW)
    ) array_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (state_q.ptr),
        .rdata (arr_rdata)
    );

    always_comb begin
        state_d      = state_q;
        state_d.rd_v = 1'b0;
        state_d.warn = 1'b0;
        state_d.cap  = 1'b0;
        arr_we       = 1'b0;
        arr_waddr    = state_q.sweep;
        arr_wdata    = ERASED_BYTE;

        // erase sweep: one byte per clock
        if (state_q.busy) begin
            arr_we        = 1'b1;
            state_d.sweep = state_q.sweep + AW'(1);
            if (state_q.left == (AW+1)'(1)) begin
                state_d.busy = 1'b0;
            end else begin
                state_d.left = state_q.left - (AW+1)'(1);
            end
        end

        if (req_valid) begin
            case (req_op)
                OP_SETADDR: state_d.ptr = req_addr;
                OP_READ: begin
                    state_d.rd   = arr_rdata;
                    state_d.rd_v = 1'b1;
                    state_d.ptr  = state_q.ptr + AW'(1);
                end
                OP_PROG: begin
                    if (!state_q.busy) begin
                        arr_we       = 1'b1;
                        arr_waddr    = state_q.ptr;
                        arr_wdata    = rewrite_ones ? req_data : (arr_rdata & req_data);
                        state_d.ptr  = state_q.ptr + AW'(1);
                        state_d.warn = !wr_en;
                    end
                end
                default: begin
                    if (!state_q.busy) begin
                        state_d.cap = geo_fault;
                        if (wr_en) begin
                            state_d.busy  = 1'b1;
                            state_d.sweep = geo_base;
                            state_d.left  = geo_len;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy      = state_q.busy;
    assign rd_data   = state_q.rd;
    assign rd_valid  = state_q.rd_v;
    assign prog_warn = state_q.warn;
    assign cap_err   = state_q.cap;
endmodule

// File: rtl/flash_eng_chk.sv
`timescale 1ns/1ps
module flash_eng_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic [1:0] req_kind,
    input logic       wr_en,
    input logic [1:0] cap_mask,
    input logic       busy,
    input logic       rd_valid,
    input logic       prog_warn,
    input logic       cap_err,
    input logic       mem_we,
    input logic [7:0] mem_wdata
);
    logic erase_req, prog_req;
    assign erase_req = req_valid && (req_op == 2'd3) && !busy;
    assign prog_req  = req_valid && (req_op == 2'd2) && !busy;

    AST_ERASE_START: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req && wr_en |=> busy); // R8
    AST_ERASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req && !wr_en |=> !busy); // R3
    AST_CAP_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req && (req_kind == 2'd0) && !cap_mask[0] |=> cap_err); // R4
    AST_CAP_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req && req_kind[1] |=> !cap_err); // R4
    AST_PROG_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && !wr_en |=> prog_warn); // R7
    AST_SWEEP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_we |-> mem_wdata == 8'hFF); // R2
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_we); // R8
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op == 2'd1) |=> rd_valid); // R10
endmodule

bind flash_eng flash_eng_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_kind  (req_kind),
    .wr_en     (wr_en),
    .cap_mask  (cap_mask),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .prog_warn (prog_warn),
    .cap_err   (cap_err),
    .mem_we    (arr_we),
    .mem_wdata (arr_wdata)
);

// File: tb/flash_eng_tb.sv
`timescale 1ns/1ps
module flash_eng_tb_top;
    localparam int ARR = 512;
    localparam int AW  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'd0;
    logic          wr_en = 1'b1;
    logic [1:0]    cap_mask = 2'b11;
    logic          rewrite_ones = 1'b0;
    logic          busy, rd_valid, prog_warn, cap_err;
    logic [7:0]    rd_data;

    int checks = 0;
    int errs   = 0;

    always #10 clk = ~clk;

    flash_eng #(
        .ARRAY_BYTES       (ARR),
        .SECTOR_BYTES      (128),
        .SMALL_ERASE_BYTES (32),
        .MID_ERASE_BYTES   (64)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_kind (req_kind), .req_addr (req_addr), .req_data (req_data),
        .wr_en (wr_en), .cap_mask (cap_mask), .rewrite_ones (rewrite_ones),
        .busy (busy), .rd_data (rd_data), .rd_valid (rd_valid),
        .prog_warn (prog_warn), .cap_err (cap_err)
    );

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          rew;
        logic [7:0]    exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 9'h010, 8'h00, 1'b0, 8'h00},
        '{2'd2, 9'h000, 8'hA5, 1'b0, 8'h00},
        '{2'd2, 9'h000, 8'h3C, 1'b0, 8'h00},
        '{2'd0, 9'h010, 8'h00, 1'b0, 8'h00},
        '{2'd1, 9'h000, 8'h00, 1'b0, 8'hA5},
        '{2'd1, 9'h000, 8'h00, 1'b0, 8'h3C},
        '{2'd0, 9'h010, 8'h00, 1'b0, 8'h00},
        '{2'd2, 9'h000, 8'h0F, 1'b0, 8'h00},
        '{2'd2, 9'h000, 8'hF0, 1'b1, 8'h00},
        '{2'd0, 9'h010, 8'h00, 1'b0, 8'h00},
        '{2'd1, 9'h000, 8'h00, 1'b0, 8'h05},
        '{2'd1, 9'h000, 8'h00, 1'b0, 8'hF0}
    };

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic req(input logic [1:0] op, input logic [1:0] kind,
                       input logic [AW-1:0] addr, input logic [7:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_kind = kind;
        req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_at(input logic [AW-1:0] addr, output logic [7:0] val);
        req(2'd0, 2'd0, addr, 8'h00);
        req(2'd1, 2'd0, 9'h000, 8'h00);
        val = rd_data;
    endtask

    task automatic prog_at(input logic [AW-1:0] addr, input logic [7:0] data);
        req(2'd0, 2'd0, addr, 8'h00);
        req(2'd2, 2'd0, 9'h000, data);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL R8 watchdog actual=hung expected=idle");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 busy", busy, 0);
        check("R9 rd_valid", rd_valid, 0);
        check("R9 flags", {prog_warn, cap_err}, 0);
        req(2'd1, 2'd0, 9'h000, 8'h00);
        check("R9 pointer starts at 0, byte 0 erased", rd_data, 8'hFF);
        read_at(9'h1FF, v);
        check("R9 top byte erased", v, 8'hFF);

        // table: program/read sequences, R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            rewrite_ones = VEC[i].rew;
            req(VEC[i].op, 2'd0, VEC[i].addr, VEC[i].data);
            if (VEC[i].op == 2'd1) begin
                check("R10 rd_valid", rd_valid, 1);
                check("R5 R6 table read", rd_data, VEC[i].exp);
            end
        end
        rewrite_ones = 1'b0;

        // R6 wrap at top
        prog_at(9'h1FF, 8'h12);
        req(2'd1, 2'd0, 9'h000, 8'h00);
        check("R6 pointer wraps to 0", rd_data, 8'hFF);
        read_at(9'h1FF, v);
        check("R6 top byte programmed", v, 8'h12);

        // R7 program without write enable
        wr_en = 1'b0;
        prog_at(9'h030, 8'h5A);
        check("R7 prog_warn pulse", prog_warn, 1);
        wr_en = 1'b1;
        read_at(9'h030, v);
        check("R7 byte still written", v, 8'h5A);
        prog_at(9'h031, 8'h5A);
        check("R7 no warn with write enable", prog_warn, 0);

        // R1 R2 R8 small erase, aligned down to 0x40
        prog_at(9'h03F, 8'h00); prog_at(9'h040, 8'h00);
        prog_at(9'h05F, 8'h00); prog_at(9'h060, 8'h00);
        req(2'd3, 2'd0, 9'h047, 8'h00);
        check("R4 small with capability, no error", cap_err, 0);
        count_busy(n);
        check("R8 R1 small erase busy cycles", n, 32);
        read_at(9'h03F, v); check("R2 below small region", v, 8'h00);
        read_at(9'h040, v); check("R2 R1 small region start", v, 8'hFF);
        read_at(9'h05F, v); check("R2 R1 small region end", v, 8'hFF);
        read_at(9'h060, v); check("R2 above small region", v, 8'h00);

        // R4 mid erase without capability still runs
        cap_mask = 2'b01;
        prog_at(9'h07F, 8'h00); prog_at(9'h080, 8'h00);
        prog_at(9'h0BF, 8'h00); prog_at(9'h0C0, 8'h00);
        req(2'd3, 2'd1, 9'h095, 8'h00);
        check("R4 cap_err pulse", cap_err, 1);
        count_busy(n);
        check("R4 R1 mid erase busy cycles", n, 64);
        read_at(9'h07F, v); check("R2 below mid region", v, 8'h00);
        read_at(9'h080, v); check("R4 R1 mid region start", v, 8'hFF);
        read_at(9'h0BF, v); check("R4 R1 mid region end", v, 8'hFF);
        read_at(9'h0C0, v); check("R2 above mid region", v, 8'h00);
        cap_mask = 2'b11;

        // R3 erase without write enable dropped
        prog_at(9'h020, 8'h00);
        wr_en = 1'b0;
        req(2'd3, 2'd0, 9'h020, 8'h00);
        check("R3 busy stays low", busy, 0);
        wr_en = 1'b1;
        read_at(9'h020, v);
        check("R3 array unchanged", v, 8'h00);

        // R8 R10 requests during busy (sector erase at 0x180)
        prog_at(9'h006, 8'h00); prog_at(9'h008, 8'h00);
        prog_at(9'h17F, 8'h00); prog_at(9'h180, 8'h00);
        req(2'd3, 2'd2, 9'h1C4, 8'h00);
        check("R8 busy after sector erase", busy, 1);
        req(2'd1, 2'd0, 9'h000, 8'h00);
        check("R10 read accepted while busy", rd_valid, 1);
        req(2'd0, 2'd0, 9'h005, 8'h00);
        req(2'd2, 2'd0, 9'h000, 8'h00);
        req(2'd3, 2'd0, 9'h000, 8'h00);
        count_busy(n);
        req(2'd1, 2'd0, 9'h000, 8'h00);
        check("R8 program ignored while busy", rd_data, 8'hFF);
        req(2'd1, 2'd0, 9'h000, 8'h00);
        check("R8 pointer not moved by ignored program", rd_data, 8'h00);
        read_at(9'h008, v); check("R8 erase ignored while busy", v, 8'h00);
        read_at(9'h17F, v); check("R2 below sector", v, 8'h00);
        read_at(9'h180, v); check("R1 sector start erased", v, 8'hFF);

        // R1 R4 chip erase, no capability bits needed
        cap_mask = 2'b00;
        req(2'd3, 2'd3, 9'h123, 8'h00);
        check("R4 chip erase never flags", cap_err, 0);
        count_busy(n);
        check("R1 chip erase busy cycles", n, ARR);
        read_at(9'h008, v); check("R1 R2 chip erase low byte", v, 8'hFF);
        read_at(9'h1FF, v); check("R1 R2 chip erase top byte", v, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule